// File: doc/BRIEF.md
# NMI Source Combiner

This block takes three event sources and drives one active-low non-maskable interrupt line to a processor. The sources are a display-list instruction flag, the start of vertical blank, and a front-panel reset button. Each source sets its own status bit whenever its event happens. The processor reads those bits to tell which source caused the interrupt. A single write strobe clears all of them at once.

Two enable bits gate the display-instruction and vertical-blank sources. Both enable bits come up cleared after reset. The button has no enable bit, so a press always interrupts the processor. The button input is asynchronous. It is synchronized and edge-detected, so one press gives one event.

Every enabled event becomes one low pulse of fixed width on the NMI line. Events that overlap are queued and issued as separate pulses, with a fixed high gap between them. The processor therefore sees a distinct falling edge for each event.

Top module: `nmi_combiner`

## Requirements
- R1: After reset, both enable bits are 0, `status_rd` reads 0x00 and `nmi_n` is high.
- R2: A cycle with `en_wr` high loads `en_wdata`. Bit 1 enables the display-instruction source and bit 0 enables the vertical-blank source. A 0 in either bit masks that source from `nmi_n`.
- R3: `status_rd` bit 7 sets when `dli_evt` is sampled high, and bit 6 sets when `vbl_evt` is sampled high. Both bits set whatever the enable bits hold. Bits 4 to 0 always read 0.
- R4: A cycle with `clr_wr` high clears status bits 7, 6 and 5 together. An event sampled in the same cycle as the clear still sets its own bit.
- R5: An enabled event sampled at a clock edge gives exactly one `nmi_n` pulse. A masked event gives none.
- R6: A rising edge of `btn_raw` sets status bit 5 and gives exactly one `nmi_n` pulse, whatever the enable bits hold. The event appears 3 clocks after `btn_raw` is first sampled high. Holding the button down gives no further events.
- R7: Each pulse holds `nmi_n` low for exactly PULSE_LEN clocks (default 2). The pulse starts right after the clock edge that samples the event.
- R8: Events that arrive together or overlap are all issued as separate pulses and none is lost. Between consecutive pulses, `nmi_n` stays high for exactly GAP_LEN clocks (default 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 2 | Enable data: bit 1 for the display instruction, bit 0 for vertical blank |
| clr_wr | input | 1 | Strobe that clears all status bits |
| dli_evt | input | 1 | Display-instruction event, one-clock pulse |
| vbl_evt | input | 1 | Vertical-blank start event, one-clock pulse |
| btn_raw | input | 1 | Asynchronous reset-button level |
| status_rd | output | 8 | Status: bit 7 display instruction, bit 6 vertical blank, bit 5 button, bits 4 to 0 zero |
| nmi_n | output | 1 | Active-low NMI to the processor |

## Verification
The bench raises both display and vertical-blank events in the same cycle under every enable pattern. It then counts the falling edges and measures each low width and high gap. A design that merged the two events would show a single pulse, or a gap shorter than two clocks. The bench also issues a status clear in the same cycle as a new event, which exposes a design that lets the clear win and drops that event. It holds the button down across many cycles to catch a level-sensitive button path, which would repeat the interrupt. It raises the display event right after reset with no enable written, which catches enable bits that do not come up cleared.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_DLI = 0;
    localparam int SRC_VBL = 1;
    localparam int SRC_BTN = 2;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOW  = 2'd1,
        PG_GAP  = 2'd2
    } pg_state_e;
endpackage

// File: rtl/nmi_btn_sync.sv
module nmi_btn_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic btn_evt
);
    localparam int NS = SYNC_STAGES + 1;

    typedef struct packed {
        logic [NS-1:0] sh;
    } bs_t;

    bs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sh = {s_q.sh[NS-2:0], btn_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign btn_evt = s_q.sh[NS-2] & ~s_q.sh[NS-1];

    // R6
    btn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btn_evt |=> !btn_evt);
endmodule

// File: rtl/nmi_pulse_gen.sv
module nmi_pulse_gen
    import nmi_pkg::*;
#(
    parameter int PULSE_LEN = 2,
    parameter int GAP_LEN   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    output logic               nmi_n
);
    localparam int MAXL = (PULSE_LEN > GAP_LEN) ? PULSE_LEN : GAP_LEN;
    localparam int CW   = (MAXL > 1) ? $clog2(MAXL) : 1;

    typedef struct packed {
        pg_state_e          state;
        logic [CW-1:0]      cnt;
        logic [NUM_SRC-1:0] pend;
    } pg_t;

    pg_t p_d, p_q;

    always_comb begin
        logic [NUM_SRC-1:0] all_pend;
        logic [NUM_SRC-1:0] grant;
        p_d      = p_q;
        all_pend = p_q.pend | req;
        grant    = all_pend & (~all_pend + NUM_SRC'(1));
        p_d.pend = all_pend;
        case (p_q.state)
            PG_IDLE: begin
                if (|all_pend) begin
                    p_d.pend  = all_pend & ~grant;
                    p_d.state = PG_LOW;
                    p_d.cnt   = '0;
                end
            end
            PG_LOW: begin
                if (p_q.cnt == CW'(PULSE_LEN - 1)) begin
                    p_d.state = PG_GAP;
                    p_d.cnt   = '0;
                end else begin
                    p_d.cnt = p_q.cnt + CW'(1);
                end
            end
            PG_GAP: begin
                if (p_q.cnt == CW'(GAP_LEN - 1)) begin
                    p_d.cnt = '0;
                    if (|all_pend) begin
                        p_d.pend  = all_pend & ~grant;
                        p_d.state = PG_LOW;
                    end else begin
                        p_d.state = PG_IDLE;
                    end
                end else begin
                    p_d.cnt = p_q.cnt + CW'(1);
                end
            end
            default: p_d.state = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.state <= PG_IDLE;
            p_q.cnt   <= '0;
            p_q.pend  <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign nmi_n = (p_q.state != PG_LOW);

    generate
        if (PULSE_LEN >= 2) begin : g_low_chk
            // R7
            low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(nmi_n) |=> !nmi_n);
        end
        if (GAP_LEN >= 2) begin : g_gap_chk
            // R8
            gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(nmi_n) |=> nmi_n);
        end
    endgenerate
endmodule

// File: rtl/nmi_combiner.sv
module nmi_combiner
    import nmi_pkg::*;
#(
    parameter int PULSE_LEN   = 2,
    parameter int GAP_LEN     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_wr,
    input  logic [1:0] en_wdata,
    input  logic       clr_wr,
    input  logic       dli_evt,
    input  logic       vbl_evt,
    input  logic       btn_raw,
    output logic [7:0] status_rd,
    output logic       nmi_n
);
    typedef struct packed {
        logic [1:0]         en;
        logic [NUM_SRC-1:0] st;
    } rg_t;

    rg_t r_d, r_q;
    logic btn_evt;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] req;

    nmi_btn_sync #(.SYNC_STAGES(SYNC_STAGES)) i_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_raw (btn_raw),
        .btn_evt (btn_evt)
    );

    always_comb begin
        evt = '0;
        evt[SRC_DLI] = dli_evt;
        evt[SRC_VBL] = vbl_evt;
        evt[SRC_BTN] = btn_evt;
        req = evt;
        req[SRC_DLI] = dli_evt & r_q.en[1];
        req[SRC_VBL] = vbl_evt & r_q.en[0];
    end

    always_comb begin
        r_d = r_q;
        if (en_wr) r_d.en = en_wdata;
        r_d.st = (clr_wr ? '0 : r_q.st) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status_rd = {r_q.st[SRC_DLI], r_q.st[SRC_VBL], r_q.st[SRC_BTN], 5'b00000};

    nmi_pulse_gen #(.PULSE_LEN(PULSE_LEN), .GAP_LEN(GAP_LEN)) i_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .nmi_n (nmi_n)
    );

    // R3
    dli_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dli_evt |=> status_rd[7]);

    // R3
    vbl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_evt |=> status_rd[6]);

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !dli_evt && !vbl_evt && !btn_evt) |=> (status_rd == 8'h00));

    // R6
    btn_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        btn_evt |=> status_rd[5]);
endmodule

// File: tb/test_nmi_combiner.sv
`timescale 1ns/1ps
module test_nmi_combiner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 1'b0;
    logic [1:0] en_wdata = 2'b00;
    logic       clr_wr = 1'b0;
    logic       dli_evt = 1'b0;
    logic       vbl_evt = 1'b0;
    logic       btn_raw = 1'b0;
    logic [7:0] status_rd;
    logic       nmi_n;

    int checks = 0;
    int failures = 0;
    int n_falls, min_low, max_low, min_gap;

    always #4 clk = ~clk;

    nmi_combiner i_nmi_combiner (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .clr_wr(clr_wr), .dli_evt(dli_evt), .vbl_evt(vbl_evt),
        .btn_raw(btn_raw), .status_rd(status_rd), .nmi_n(nmi_n)
    );

    // Vector fields: [5] dli enable, [4] vbl enable, [3] dli event, [2] vbl event, [1:0] expected pulses
    localparam logic [5:0] VEC [0:7] = '{
        6'b111110, 6'b111001, 6'b110101, 6'b001100,
        6'b101101, 6'b011101, 6'b011000, 6'b100100
    };

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_en(input logic [1:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk); clr_wr = 1'b1;
        @(negedge clk); clr_wr = 1'b0;
    endtask

    // Samples nmi_n at n negedges, counting pulses, widths and gaps
    task automatic window(input int n);
        logic prev = 1'b1;
        int run_low = 0;
        int run_high = 0;
        bit seen = 0;
        n_falls = 0; min_low = 1000; max_low = 0; min_gap = 1000;
        for (int i = 0; i < n; i++) begin
            if (!nmi_n) begin
                if (prev) begin
                    n_falls++;
                    if (seen && run_high < min_gap) min_gap = run_high;
                    run_low = 0;
                end
                run_low++;
            end else begin
                if (!prev) begin
                    if (run_low < min_low) min_low = run_low;
                    if (run_low > max_low) max_low = run_low;
                    seen = 1;
                    run_high = 0;
                end
                run_high++;
            end
            prev = nmi_n;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 status after reset", status_rd, 0);
        check_eq("R1 nmi_n after reset", nmi_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R5: enables cleared by reset, so a display event only latches status
        dli_evt = 1'b1;
        @(negedge clk); dli_evt = 1'b0;
        window(10);
        check_eq("R1 no pulse with reset enables", n_falls, 0);
        check_eq("R3 status bit7 while masked", status_rd, 8'h80);

        // R4: a clear and a new event in the same cycle, event wins
        @(negedge clk); clr_wr = 1'b1; vbl_evt = 1'b1;
        @(negedge clk); clr_wr = 1'b0; vbl_evt = 1'b0;
        check_eq("R4 event wins over clear", status_rd, 8'h40);
        clear_status();
        check_eq("R4 clear all", status_rd, 0);

        // Table walk: R2, R3, R5, R7, R8
        foreach (VEC[k]) begin
            clear_status();
            write_en(VEC[k][5:4]);
            @(negedge clk); dli_evt = VEC[k][3]; vbl_evt = VEC[k][2];
            @(negedge clk); dli_evt = 1'b0; vbl_evt = 1'b0;
            window(14);
            check_eq("R2 R5 pulse count", n_falls, int'(VEC[k][1:0]));
            check_eq("R3 status", status_rd, int'({VEC[k][3], VEC[k][2], 6'b0}));
            if (VEC[k][1:0] != 0) begin
                check_eq("R7 min low width", min_low, 2);
                check_eq("R7 max low width", max_low, 2);
            end
            if (VEC[k][1:0] == 2) check_eq("R8 gap width", min_gap, 2);
        end

        // R6: button with both enables off, held long
        clear_status();
        write_en(2'b00);
        @(negedge clk); btn_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_eq("R6 no event before sync latency", nmi_n, 1);
        @(negedge clk);
        check_eq("R6 pulse after 3 clocks", nmi_n, 0);
        window(20);
        check_eq("R6 one pulse per held press", n_falls, 1);
        check_eq("R6 status bit5", status_rd, 8'h20);
        @(negedge clk); btn_raw = 1'b0;
        repeat (4) @(negedge clk);
        btn_raw = 1'b1;
        window(20);
        check_eq("R6 second press pulses", n_falls, 1);
        btn_raw = 1'b0;

        // R8: button event lands while a display pulse is active
        clear_status();
        write_en(2'b11);
        @(negedge clk); btn_raw = 1'b1;
        @(negedge clk); @(negedge clk); dli_evt = 1'b1;
        @(negedge clk); dli_evt = 1'b0;
        window(16);
        check_eq("R8 overlap pulses", n_falls, 2);
        check_eq("R8 overlap gap", min_gap, 2);
        check_eq("R3 R6 overlap status", status_rd, 8'hA0);
        btn_raw = 1'b0;

        // R1: reset in the middle of activity
        @(negedge clk); vbl_evt = 1'b1;
        @(negedge clk); vbl_evt = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check_eq("R1 status on reset", status_rd, 0);
        check_eq("R1 nmi_n on reset", nmi_n, 1);
        rst_n = 1'b1;
        @(negedge clk); vbl_evt = 1'b1;
        @(negedge clk); vbl_evt = 1'b0;
        window(8);
        check_eq("R1 enables cleared again", n_falls, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule